// File: doc/BRIEF.md
# Serial Receive Channel with Error Detection

This block is the receive half of a programmable serial port. It samples a serial line once per pulse of a receive-clock strobe and shifts bits in LSB first. From the shifted bits it builds fixed-width characters. Each finished character goes into a holding register and raises a ready flag, which stays up until the host reads the register.

Asynchronous mode runs at a selectable clock factor. Each start bit is confirmed at its centre, and each character is checked for parity and for a valid stop bit. Synchronous mode shifts one bit per strobe. Assembly starts when an external sync-detect input is high, and after that characters follow one another with no framing bits.

Four conditions raise flags:
- A character that arrives while the previous one is still unread sets an overrun flag.
- A parity mismatch sets a parity flag.
- A missing stop bit sets a framing flag.
- Two all-zero characters in a row, each with a low stop bit, raise a break output.

The three error flags hold until the host clears them. The break output drops as soon as the line returns to mark.

Top module: `serial_rx_channel`

## Requirements
- R1: When a character completes (at the stop-bit sample in asynchronous mode, or at the last data or parity bit in synchronous mode), `rx_rdy` goes high on the next clock. `rx_data` then holds the character, with the first received bit in bit 0.
- R2: A one-cycle `rd_data` pulse clears `rx_rdy` on the next clock. A character that completes in the same cycle takes priority and keeps `rx_rdy` high.
- R3: If a character completes while `rx_rdy` is still high and no read is happening, `ovr_err` is set and `rx_data` is overwritten with the new character.
- R4: In asynchronous mode `factor_sel` sets the number of strobes per bit: 00 gives 1, 01 gives 16, and 10 or 11 gives 64. Bits are sampled at their centres.
- R5: In asynchronous mode with a factor above 1, a low level on `rxd` that is no longer low half a bit time after it was first seen is discarded, and no character is produced.
- R6: When `parity_en` is 1, one parity bit follows the data bits. `parity_odd` = 0 selects even parity and 1 selects odd parity, and a mismatch sets `par_err`.
- R7: In asynchronous mode, a low stop-bit sample sets `frm_err`. The character is still delivered.
- R8: `brk_det` goes high when two consecutive asynchronous characters have all sampled bits low, including the stop bit. It clears after any strobe on which `rxd` is high. A single such character does not raise it.
- R9: With `mode_sync` = 1, nothing is assembled until a strobe sees `syndet_in` high. From the next strobe onward, one bit is taken per strobe, and characters follow back to back.
- R10: `ovr_err`, `frm_err` and `par_err` stay set, even across reads, until an `err_clr` pulse.
- R11: After reset, `rx_rdy`, `brk_det`, `ovr_err`, `frm_err` and `par_err` are all low.
- R12: While `rx_en` is 0, the receiver stays idle and no character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| rxc_tick | input | 1 | Receive-clock strobe, one clock wide |
| rxd | input | 1 | Serial data line, idle high |
| mode_sync | input | 1 | 1 = synchronous with external sync detect |
| factor_sel | input | 2 | Asynchronous clock factor select |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| syndet_in | input | 1 | External sync-detect (synchronous mode) |
| rd_data | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clear the sticky error flags |
| rx_data | output | DATA_W | Received character |
| rx_rdy | output | 1 | Character waiting to be read |
| brk_det | output | 1 | Break detected |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |

## Verification
A character finishes on the strobe that samples its stop bit, or its last bit in synchronous mode. `rx_rdy`, `rx_data` and the error flags settle on the clock edge at the end of that strobe cycle. The bench therefore drives strobes one cycle wide with an idle cycle between them, and reads the outputs at a falling edge at least two strobes after the frame ends. `rd_data` and `err_clr` take effect one clock after their pulse, so their results are sampled at the following falling edge. The break output clears on the edge after a strobe that sees the line high, and it is checked one cycle later.

// File: rtl/serial_rx_channel.sv
module serial_rx_channel #(
  parameter int DATA_W = 8,
  parameter int FAC_MID = 16,
  parameter int FAC_HI = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rxc_tick,
  input  logic              rxd,
  input  logic              mode_sync,
  input  logic [1:0]        factor_sel,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              syndet_in,
  input  logic              rd_data,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_rdy,
  output logic              brk_det,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              par_err
);
  localparam int CW = $clog2(FAC_HI + 1) + 1;
  localparam int BW = $clog2(DATA_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t st;

  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              pbit, any_one, zprev;

  logic [CW-1:0] fac, half;
  logic [DATA_W-1:0] nsh, char_w;
  logic samp, last_dat, fin, par_w, perr_w, zchar;

  assign fac = mode_sync ? CW'(1) :
               (factor_sel == 2'd0) ? CW'(1) :
               (factor_sel == 2'd1) ? CW'(FAC_MID) : CW'(FAC_HI);
  assign half     = fac >> 1;
  assign samp     = rxc_tick && (cnt == fac);
  assign nsh      = {rxd, sh[DATA_W-1:1]};
  assign last_dat = (bitn == BW'(DATA_W - 1));
  assign fin      = rx_en && samp &&
                    ((st == S_STOP) ||
                     (mode_sync && ((st == S_DATA && last_dat && !parity_en) || st == S_PAR)));
  assign char_w   = (st == S_DATA) ? nsh : sh;
  assign par_w    = (st == S_PAR) ? rxd : pbit;
  assign perr_w   = parity_en && ((^char_w ^ par_w) != parity_odd);
  assign zchar    = !any_one && !rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      bitn <= '0;
      sh <= '0;
      pbit <= 1'b0;
      any_one <= 1'b0;
      zprev <= 1'b0;
      rx_data <= '0;
      rx_rdy <= 1'b0;
      brk_det <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (rd_data) rx_rdy <= 1'b0;
      if (err_clr) begin
        ovr_err <= 1'b0;
        frm_err <= 1'b0;
        par_err <= 1'b0;
      end
      if (rxc_tick && rxd) begin
        brk_det <= 1'b0;
        zprev <= 1'b0;
      end
      if (!rx_en) begin
        st <= S_IDLE;
      end else if (rxc_tick) begin
        unique case (st)
          S_IDLE: begin
            any_one <= 1'b0;
            bitn <= '0;
            cnt <= CW'(1);
            if (mode_sync) begin
              if (syndet_in) st <= S_DATA;
            end else if (!rxd) begin
              st <= (half == '0) ? S_DATA : S_START;
            end
          end
          S_START: begin
            if (cnt == half) begin
              st <= rxd ? S_IDLE : S_DATA;
              cnt <= CW'(1);
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (samp) begin
              sh <= nsh;
              any_one <= any_one | rxd;
              cnt <= CW'(1);
              bitn <= bitn + 1'b1;
              if (last_dat) begin
                bitn <= '0;
                st <= parity_en ? S_PAR : (mode_sync ? S_DATA : S_STOP);
              end
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (samp) begin
              pbit <= rxd;
              any_one <= any_one | rxd;
              cnt <= CW'(1);
              st <= mode_sync ? S_DATA : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (samp) st <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (fin) begin
        rx_data <= char_w;
        rx_rdy <= 1'b1;
        if (rx_rdy && !rd_data) ovr_err <= 1'b1;
        if (perr_w) par_err <= 1'b1;
        if (st == S_STOP) begin
          if (!rxd) frm_err <= 1'b1;
          if (zchar) begin
            if (zprev) brk_det <= 1'b1;
            zprev <= 1'b1;
          end else zprev <= 1'b0;
        end
      end
    end
  end
endmodule

module serial_rx_channel_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rxc_tick,
  input logic rxd,
  input logic rd_data,
  input logic err_clr,
  input logic fin,
  input logic rx_rdy,
  input logic brk_det,
  input logic ovr_err,
  input logic frm_err,
  input logic par_err
);
  p_rdy_set_r1: assert property (@(posedge clk) disable iff (!rst_n) fin |=> rx_rdy);
  p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !fin) |=> !rx_rdy);
  p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rx_rdy && !rd_data) |=> ovr_err);
  p_brk_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rxc_tick && rxd) |=> !brk_det);
  p_brk_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> $past(fin));
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !err_clr) |=> ovr_err);
  p_frm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_err && !err_clr) |=> frm_err);
  p_par_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !err_clr) |=> par_err);
  p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rx_rdy));
endmodule

bind serial_rx_channel serial_rx_channel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_tick(rxc_tick), .rxd(rxd),
  .rd_data(rd_data), .err_clr(err_clr), .fin(fin), .rx_rdy(rx_rdy),
  .brk_det(brk_det), .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err)
);

// File: tb/serial_rx_channel_tb_top.sv
`timescale 1ns/1ps
module serial_rx_channel_tb_top;
  logic clk = 0, rst_n = 0, rx_en = 1, rxc_tick = 0, rxd = 1, mode_sync = 0;
  logic [1:0] factor_sel = 0;
  logic parity_en = 0, parity_odd = 0, syndet_in = 0, rd_data = 0, err_clr = 0;
  logic [7:0] rx_data;
  logic rx_rdy, brk_det, ovr_err, frm_err, par_err;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_rx_channel dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxc_tick(rxc_tick), .rxd(rxd),
    .mode_sync(mode_sync), .factor_sel(factor_sel), .parity_en(parity_en),
    .parity_odd(parity_odd), .syndet_in(syndet_in), .rd_data(rd_data),
    .err_clr(err_clr), .rx_data(rx_data), .rx_rdy(rx_rdy), .brk_det(brk_det),
    .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err)
  );

  function automatic int fac_of(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 16 : 64;
  endfunction

  function automatic logic par_of(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxc_tick = 1;
      @(negedge clk) rxc_tick = 0;
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_data = 1;
    @(negedge clk) rd_data = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1;
    @(negedge clk) err_clr = 0;
  endtask

  task automatic send_async(logic [7:0] d, logic badpar, logic stopb);
    int f = fac_of(factor_sel);
    rxd = 0; tick(f);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; tick(f); end
    if (parity_en) begin rxd = par_of(d, parity_odd) ^ badpar; tick(f); end
    rxd = stopb; tick(f);
    rxd = 1; tick(2);
  endtask

  task automatic send_sync_bits(logic [7:0] d);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; tick(1); end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R11 rdy", rx_rdy, 0); check("R11 brk", brk_det, 0);
    check("R11 errs", {ovr_err, frm_err, par_err}, 0);
    rst_n = 1;
    tick(2);

    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom);
      factor_sel = 2'($urandom % 3);
      parity_en = 1'($urandom); parity_odd = 1'($urandom);
      send_async(d, 0, 1);
      check("R1/R4 rdy", rx_rdy, 1); check("R1/R4 data", rx_data, d);
      check("R6 no par err", par_err, 0); check("R7 no frm err", frm_err, 0);
      pulse_rd();
      check("R2 read clears", rx_rdy, 0);
    end

    factor_sel = 2'd3; parity_en = 0;
    send_async(8'hC3, 0, 1);
    check("R4 factor 64", rx_data, 8'hC3); pulse_rd();

    factor_sel = 2'd1;
    rxd = 0; tick(3); rxd = 1; tick(24);
    check("R5 glitch rejected", rx_rdy, 0);
    send_async(8'h3C, 0, 1);
    check("R5 after glitch", rx_data, 8'h3C); pulse_rd();

    parity_en = 1; parity_odd = 1;
    send_async(8'h81, 1, 1);
    check("R6 par err", par_err, 1); check("R6 data kept", rx_data, 8'h81);
    pulse_rd();
    check("R10 par sticky", par_err, 1);
    pulse_clr(); check("R10 clr", par_err, 0);
    parity_en = 0;

    factor_sel = 2'd0;
    send_async(8'h5A, 0, 0);
    check("R7 frm err", frm_err, 1); check("R7 data", rx_data, 8'h5A);
    check("R8 no brk", brk_det, 0);
    pulse_rd(); pulse_clr();

    send_async(8'hA1, 0, 1);
    d2 = 8'($urandom);
    send_async(d2, 0, 1);
    check("R3 ovr", ovr_err, 1); check("R3 newest", rx_data, d2);
    pulse_rd();
    check("R10 ovr sticky", ovr_err, 1);
    pulse_clr(); check("R10 ovr clr", ovr_err, 0);

    send_async(8'h00, 0, 0);
    check("R8 single zero no brk", brk_det, 0);
    pulse_rd(); pulse_clr();

    rxd = 0; tick(22);
    check("R8 brk set", brk_det, 1);
    rxd = 1; tick(1); @(negedge clk);
    check("R8 brk clear", brk_det, 0);
    tick(14); pulse_rd(); pulse_clr();
    check("R8 settle", rx_rdy, 0);

    rx_en = 0;
    send_async(8'h77, 0, 1);
    check("R12 disabled", rx_rdy, 0);
    rx_en = 1; tick(2);

    mode_sync = 1;
    for (int i = 0; i < 6; i++) begin rxd = 1'($urandom); tick(1); end
    check("R9 waits for sync", rx_rdy, 0);
    syndet_in = 1; tick(1); syndet_in = 0;
    d = 8'($urandom);
    send_sync_bits(d);
    check("R9 char1", rx_data, d); check("R9 rdy", rx_rdy, 1);
    pulse_rd();
    d2 = 8'($urandom);
    send_sync_bits(d2);
    check("R9 char2", rx_data, d2); check("R9 rdy2", rx_rdy, 1);
    check("R9 no ovr", ovr_err, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule